// File: doc/BRIEF.md
# Reorder Buffer with Bandwidth-Limited Squash

This block keeps the instructions that are in flight in program order, in a circular buffer of `DEPTH` slots. A dispatch stage writes a new entry (PC, next PC, sequence number) at the tail and receives the slot index back. A writeback stage later marks that slot ready to commit. The commit stage retires only the oldest entry, and only when that entry is marked ready. The block also reports the free slot count, the oldest and newest entries' PC and sequence number, and the oldest entry's next PC.

When a mispredict or exception is detected, the block receives a squash request that carries a sequence number. Over the following cycles the buffer walks backward from the newest entry and handles at most `SQ_W` slots per cycle. Each slot that is younger than the squash point is flagged as squashed and as ready. No slot is deleted. The flagged entries leave through the normal retire path, and the commit stage sees `head_squashed` on each of them so that it can discard the result. The walk stops when it reaches the entry whose sequence number equals the request; that entry is left unchanged. It also stops after it flags the oldest entry. While the walk runs, both dispatch and retirement are held off. `squash_done` rises again when the walk ends.

Top module: `rob_top`

## Requirements
- R1: `disp_ready` is 1 exactly when fewer than `DEPTH` entries are held and no squash walk is running. An accepted dispatch writes slot `disp_idx`, which is the tail index and advances by one (mod `DEPTH`) per dispatch.
- R2: `free_cnt` equals `DEPTH` minus the occupancy. A dispatch and a retirement in the same cycle leave the occupancy unchanged.
- R3: `head_ready` is 1 only when the buffer is non-empty, the oldest entry is marked ready, and no walk is running. `retire_en` removes the oldest entry only while `head_ready` is 1. Otherwise it has no effect.
- R4: A squash request is accepted only when no walk is running and the buffer was non-empty at the start of that cycle. In all other cases it is ignored. When accepted, `squash_done` reads 0 from the next cycle. The walk starts at the newest entry, which includes an entry dispatched in the same cycle.
- R5: The walk checks at most `SQ_W` slots per cycle, moving from newest to oldest. It ends at the slot whose sequence number equals the request and leaves that slot unchanged. `squash_done` stays 0 for ceil((m+1)/`SQ_W`) cycles, where m is the number of younger entries. Every slot passed must carry a sequence number greater than the request.
- R6: Each slot that the walk passes becomes squashed and ready. Once the walk has ended, such an oldest entry shows `head_squashed`=1 and `head_ready`=1.
- R7: If no slot matches, the walk ends after it flags the oldest entry. With n entries, `squash_done` stays 0 for ceil(n/`SQ_W`) cycles.
- R8: `head_pc`, `head_npc` and `head_seq` show the oldest entry. `tail_pc` and `tail_seq` show the newest entry.
- R9: `cmpl_valid` with `cmpl_idx` marks that slot ready to commit from the next cycle.
- R10: After reset the buffer is empty, with `free_cnt`=`DEPTH`, `squash_done`=1, `head_ready`=0 and `disp_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Dispatch can be accepted |
| disp_pc | input | PC_W | PC of the new entry |
| disp_npc | input | PC_W | Next PC of the new entry |
| disp_seq | input | SEQ_W | Sequence number of the new entry |
| disp_idx | output | IDX_W | Slot the new entry is written to |
| cmpl_valid | input | 1 | Mark a slot ready to commit |
| cmpl_idx | input | IDX_W | Slot to mark ready |
| retire_en | input | 1 | Retire the oldest entry if it is ready |
| head_ready | output | 1 | Oldest entry can retire |
| head_squashed | output | 1 | Oldest entry is flagged squashed |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Sequence number of the squash point |
| squash_done | output | 1 | No squash walk running |
| free_cnt | output | IDX_W+1 | Free slot count |
| head_pc | output | PC_W | Oldest entry PC |
| head_npc | output | PC_W | Oldest entry next PC |
| head_seq | output | SEQ_W | Oldest entry sequence number |
| tail_pc | output | PC_W | Newest entry PC |
| tail_seq | output | SEQ_W | Newest entry sequence number |

## Verification
A squash request can arrive in the same cycle as a dispatch, and it can also arrive in the same cycle as the retirement of the oldest entry. Both collisions are driven on purpose in directed cases and also arise in the seeded random traffic. In the dispatch case, the newly written entry must be the first one flagged. In the retire case, the walk must stop at the new oldest entry, or end at once if the buffer has emptied. The bench judges each collision by the exact number of cycles `squash_done` stays low, by `head_squashed` on every entry that drains afterwards, and by the occupancy, all compared with its own model.

// File: rtl/rob_pkg.sv
// Package: shared types for the reorder buffer.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package rob_pkg;

    // Per-slot status flags
    typedef struct packed {
        logic rdy;   // may retire
        logic sqd;   // flagged by a squash walk
    } ent_flags_t;

endpackage

// File: rtl/rob_ptrs.sv
// Module: rob_ptrs
// Keeps the oldest-slot index, the next-write index and an explicit
// occupancy counter. Assumes DEPTH is a power of two, so the indices wrap
// naturally, and that the caller never inserts when full or removes when empty.
module rob_ptrs #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins,
    input  logic             rem,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] count
);

    // Advance the indices and track the occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (ins) tail <= tail + 1'b1;
            if (rem) head <= head + 1'b1;
            if (ins && !rem)      count <= count + 1'b1;
            else if (!ins && rem) count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/rob_store.sv
// Module: rob_store
// Slot storage: the payload and the status flags of each slot. A write
// clears the flags. A completion sets ready. A squash mark sets both ready
// and squashed. Assumes a write never targets a slot that is marked in the
// same cycle (dispatch is held off during a walk).
module rob_store
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PC_W  = 32,
    parameter int SEQ_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PC_W-1:0]  wr_pc,
    input  logic [PC_W-1:0]  wr_npc,
    input  logic [SEQ_W-1:0] wr_seq,
    input  logic             cm_en,
    input  logic [IDX_W-1:0] cm_idx,
    input  logic [DEPTH-1:0] mark,
    output logic [PC_W-1:0]  pc_arr  [DEPTH],
    output logic [PC_W-1:0]  npc_arr [DEPTH],
    output logic [SEQ_W-1:0] seq_arr [DEPTH],
    output ent_flags_t       flg_arr [DEPTH]
);

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        // Update one slot: payload on write, flags on completion or squash
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pc_arr[e]  <= '0;
                npc_arr[e] <= '0;
                seq_arr[e] <= '0;
                flg_arr[e] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                pc_arr[e]  <= wr_pc;
                npc_arr[e] <= wr_npc;
                seq_arr[e] <= wr_seq;
                flg_arr[e] <= '0;
            end else if (mark[e]) begin
                flg_arr[e] <= '{rdy: 1'b1, sqd: 1'b1};
            end else if (cm_en && cm_idx == IDX_W'(e)) begin
                flg_arr[e].rdy <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rob_walk.sv
// Module: rob_walk
// Squash walker. When started, it records the squash point and a start
// slot. Each cycle it then checks up to SQ_W slots, newest to oldest. It
// marks every slot that does not match, and finishes on a match, after
// marking the oldest slot, or when the buffer is empty. Assumes that the
// head index and the occupancy stay stable while it is busy.
module rob_walk #(
    parameter int DEPTH = 8,
    parameter int SQ_W  = 2,
    parameter int SEQ_W = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] start_ptr,
    input  logic [SEQ_W-1:0] req_seq,
    input  logic [IDX_W-1:0] head,
    input  logic [CNT_W-1:0] count,
    input  logic [SEQ_W-1:0] seq_arr [DEPTH],
    output logic [DEPTH-1:0] mark,
    output logic             busy,
    output logic [IDX_W-1:0] ptr,
    output logic [SEQ_W-1:0] tgt
);

    logic             fin;
    logic [IDX_W-1:0] nxt;

    // Lane chain: decide this cycle's marks and where the walk goes next
    always_comb begin
        logic stop;
        mark = '0;
        fin  = 1'b0;
        stop = 1'b0;
        nxt  = ptr;
        for (int k = 0; k < SQ_W; k++) begin
            if (busy && !stop) begin
                if (count == '0 || seq_arr[nxt] == tgt) begin
                    fin  = 1'b1;
                    stop = 1'b1;
                end else begin
                    mark[nxt] = 1'b1;
                    if (nxt == head) begin
                        fin  = 1'b1;
                        stop = 1'b1;
                    end else begin
                        nxt = nxt - 1'b1;
                    end
                end
            end
        end
    end

    // Walk state: start, step, or finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ptr  <= '0;
            tgt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            ptr  <= start_ptr;
            tgt  <= req_seq;
        end else if (busy && fin) begin
            busy <= 1'b0;
        end else if (busy) begin
            ptr  <= nxt;
        end
    end

endmodule

// File: rtl/rob_top.sv
// Module: rob_top
// Reorder buffer top: combines the pointers, the slot storage and the squash
// walker, and gates dispatch, retirement and squash acceptance. Assumes
// DEPTH is a power of two, SQ_W >= 1, and that sequence numbers increase
// with program order and do not wrap.
module rob_top
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SQ_W  = 2,
    parameter int PC_W  = 32,
    parameter int SEQ_W = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    output logic             disp_ready,
    input  logic [PC_W-1:0]  disp_pc,
    input  logic [PC_W-1:0]  disp_npc,
    input  logic [SEQ_W-1:0] disp_seq,
    output logic [IDX_W-1:0] disp_idx,
    input  logic             cmpl_valid,
    input  logic [IDX_W-1:0] cmpl_idx,
    input  logic             retire_en,
    output logic             head_ready,
    output logic             head_squashed,
    input  logic             squash_valid,
    input  logic [SEQ_W-1:0] squash_seq,
    output logic             squash_done,
    output logic [CNT_W-1:0] free_cnt,
    output logic [PC_W-1:0]  head_pc,
    output logic [PC_W-1:0]  head_npc,
    output logic [SEQ_W-1:0] head_seq,
    output logic [PC_W-1:0]  tail_pc,
    output logic [SEQ_W-1:0] tail_seq
);

    logic [IDX_W-1:0] head_q, tail_q, newest, walk_ptr, start_ptr;
    logic [CNT_W-1:0] count_q;
    logic [DEPTH-1:0] mark;
    logic             walk_busy, disp_fire, ret_fire, sq_accept;
    logic [SEQ_W-1:0] walk_tgt, walk_seq;
    logic [PC_W-1:0]  pc_arr  [DEPTH];
    logic [PC_W-1:0]  npc_arr [DEPTH];
    logic [SEQ_W-1:0] seq_arr [DEPTH];
    ent_flags_t       flg_arr [DEPTH];

    // Handshake gating for dispatch, retirement and squash start
    always_comb begin
        disp_ready = (count_q != CNT_W'(DEPTH)) && !walk_busy;
        disp_fire  = disp_valid && disp_ready;
        head_ready = (count_q != '0) && flg_arr[head_q].rdy && !walk_busy;
        ret_fire   = retire_en && head_ready;
        sq_accept  = squash_valid && !walk_busy && (count_q != '0);
        newest     = tail_q - 1'b1;
        start_ptr  = disp_fire ? tail_q : newest;
        walk_seq   = seq_arr[walk_ptr];
    end

    // Status and head/tail views
    assign disp_idx      = tail_q;
    assign squash_done   = !walk_busy;
    assign free_cnt      = CNT_W'(DEPTH) - count_q;
    assign head_squashed = flg_arr[head_q].sqd;
    assign head_pc       = pc_arr[head_q];
    assign head_npc      = npc_arr[head_q];
    assign head_seq      = seq_arr[head_q];
    assign tail_pc       = pc_arr[newest];
    assign tail_seq      = seq_arr[newest];

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .ins   (disp_fire),
        .rem   (ret_fire),
        .head  (head_q),
        .tail  (tail_q),
        .count (count_q)
    );

    rob_store #(.DEPTH(DEPTH), .PC_W(PC_W), .SEQ_W(SEQ_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (disp_fire),
        .wr_idx  (tail_q),
        .wr_pc   (disp_pc),
        .wr_npc  (disp_npc),
        .wr_seq  (disp_seq),
        .cm_en   (cmpl_valid),
        .cm_idx  (cmpl_idx),
        .mark    (mark),
        .pc_arr  (pc_arr),
        .npc_arr (npc_arr),
        .seq_arr (seq_arr),
        .flg_arr (flg_arr)
    );

    rob_walk #(.DEPTH(DEPTH), .SQ_W(SQ_W), .SEQ_W(SEQ_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sq_accept),
        .start_ptr (start_ptr),
        .req_seq   (squash_seq),
        .head      (head_q),
        .count     (count_q),
        .seq_arr   (seq_arr),
        .mark      (mark),
        .busy      (walk_busy),
        .ptr       (walk_ptr),
        .tgt       (walk_tgt)
    );

endmodule

// File: rtl/rob_chk.sv
// Module: rob_chk
// Protocol checker bound to rob_top. It watches the ports and the walk
// state. Assumes a synchronous active-low reset.
module rob_chk #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic             retire_en,
    input logic             head_ready,
    input logic             head_squashed,
    input logic             squash_valid,
    input logic             squash_done,
    input logic [CNT_W-1:0] free_cnt,
    input logic             walk_busy,
    input logic [SEQ_W-1:0] walk_seq,
    input logic [SEQ_W-1:0] walk_tgt
);

    AST_FREE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> int'(free_cnt) == int'($past(free_cnt))
            - int'($past(disp_valid && disp_ready)) + int'($past(retire_en && head_ready))); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt == '0 |-> !disp_ready); // R1

    AST_WALK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !squash_done |-> !disp_ready && !head_ready); // R1

    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt == CNT_W'(DEPTH) |-> !head_ready); // R3

    AST_SQ_START: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid && squash_done && free_cnt != CNT_W'(DEPTH) |=> !squash_done); // R4

    AST_SQ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        walk_busy && free_cnt != CNT_W'(DEPTH) && walk_seq != walk_tgt |-> walk_seq > walk_tgt); // R5

    AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        squash_done && head_squashed && free_cnt != CNT_W'(DEPTH) |-> head_ready); // R6

endmodule

bind rob_top rob_chk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .disp_valid    (disp_valid),
    .disp_ready    (disp_ready),
    .retire_en     (retire_en),
    .head_ready    (head_ready),
    .head_squashed (head_squashed),
    .squash_valid  (squash_valid),
    .squash_done   (squash_done),
    .free_cnt      (free_cnt),
    .walk_busy     (walk_busy),
    .walk_seq      (walk_seq),
    .walk_tgt      (walk_tgt)
);

// File: tb/rob_top_bench.sv
module rob_top_bench;
    localparam int DEPTH = 8;
    localparam int SQW   = 2;
    localparam int PCW   = 32;
    localparam int SEQW  = 16;
    localparam int IW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 1'b0, cmpl_valid = 1'b0, retire_en = 1'b0, squash_valid = 1'b0;
    logic [PCW-1:0] disp_pc = '0, disp_npc = '0;
    logic [SEQW-1:0] disp_seq = '0, squash_seq = '0;
    logic [IW-1:0] cmpl_idx = '0;
    logic disp_ready, head_ready, head_squashed, squash_done;
    logic [IW-1:0] disp_idx;
    logic [IW:0] free_cnt;
    logic [PCW-1:0] head_pc, head_npc, tail_pc;
    logic [SEQW-1:0] head_seq, tail_seq;

    always #5 clk = ~clk;

    rob_top #(.DEPTH(DEPTH), .SQ_W(SQW), .PC_W(PCW), .SEQ_W(SEQW)) u_rob_top (.*);

    // Bench model of the buffer
    logic [PCW-1:0]  m_pc  [DEPTH];
    logic [PCW-1:0]  m_npc [DEPTH];
    logic [SEQW-1:0] m_seq [DEPTH];
    bit              m_rdy [DEPTH];
    bit              m_sqd [DEPTH];
    int m_head = 0, m_tail = 0, m_cnt = 0, walk_left = 0;
    int next_seq = 1;
    string sq_tag = "R5";
    int n_cmp = 0, n_bad = 0;

    task automatic chk(string rq, string nm, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, nm, act, exp);
        end
    endtask

    function automatic bit exp_head_ready();
        return m_cnt != 0 && m_rdy[m_head] && walk_left == 0;
    endfunction

    task automatic check_all();
        chk("R2", "free_cnt", free_cnt, DEPTH - m_cnt);
        chk("R1", "disp_ready", disp_ready, (m_cnt != DEPTH) && walk_left == 0);
        chk("R1", "disp_idx", disp_idx, m_tail);
        chk("R3", "head_ready", head_ready, exp_head_ready());
        chk(sq_tag, "squash_done", squash_done, walk_left == 0);
        if (m_cnt != 0) begin
            chk("R8", "head_pc", head_pc, m_pc[m_head]);
            chk("R8", "head_npc", head_npc, m_npc[m_head]);
            chk("R8", "head_seq", head_seq, m_seq[m_head]);
            chk("R8", "tail_pc", tail_pc, m_pc[(m_tail + DEPTH - 1) % DEPTH]);
            chk("R8", "tail_seq", tail_seq, m_seq[(m_tail + DEPTH - 1) % DEPTH]);
            if (walk_left == 0) chk("R6", "head_squashed", head_squashed, m_sqd[m_head]);
        end
    endtask

    // Apply one clock edge to both the DUT and the model, then compare
    task automatic cycle();
        bit dfire, rfire, sacc;
        dfire = disp_valid && m_cnt != DEPTH && walk_left == 0;
        rfire = retire_en && exp_head_ready();
        sacc  = squash_valid && walk_left == 0 && m_cnt != 0;
        @(posedge clk);
        #1;
        if (walk_left > 0) walk_left--;
        if (cmpl_valid) m_rdy[cmpl_idx] = 1;
        if (rfire) begin m_head = (m_head + 1) % DEPTH; m_cnt--; end
        if (dfire) begin
            m_pc[m_tail] = disp_pc; m_npc[m_tail] = disp_npc; m_seq[m_tail] = disp_seq;
            m_rdy[m_tail] = 0; m_sqd[m_tail] = 0;
            m_tail = (m_tail + 1) % DEPTH; m_cnt++; next_seq++;
        end
        if (sacc) begin
            int idx, uses;
            idx = (m_tail + DEPTH - 1) % DEPTH;
            uses = 0;
            sq_tag = "R7";
            forever begin
                uses++;
                if (m_cnt == 0) break;
                if (m_seq[idx] == squash_seq) begin sq_tag = "R5"; break; end
                m_rdy[idx] = 1; m_sqd[idx] = 1;
                if (idx == m_head) break;
                idx = (idx + DEPTH - 1) % DEPTH;
            end
            walk_left = (uses + SQW - 1) / SQW;
            chk("R4", "squash_done_drop", squash_done, 0);
        end
        check_all();
        disp_valid = 0; cmpl_valid = 0; retire_en = 0; squash_valid = 0;
    endtask

    task automatic drive_disp();
        disp_valid = 1;
        disp_pc  = $urandom;
        disp_npc = disp_pc + 4;
        disp_seq = SEQW'(next_seq);
    endtask

    task automatic wait_walk();
        while (walk_left > 0) cycle();
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R10: reset state
        chk("R10", "free_cnt", free_cnt, DEPTH);
        chk("R10", "squash_done", squash_done, 1);
        chk("R10", "head_ready", head_ready, 0);
        chk("R10", "disp_ready", disp_ready, 1);

        // R4: squash on empty buffer is ignored
        squash_valid = 1; squash_seq = 0; cycle();
        chk("R4", "empty_ignore", squash_done, 1);

        // R1: fill to capacity, then an extra dispatch is refused
        for (int i = 0; i < DEPTH; i++) begin drive_disp(); cycle(); end
        chk("R1", "full_ready", disp_ready, 0);
        drive_disp(); cycle();
        chk("R1", "full_count", free_cnt, 0);

        // R3: retire request on a not-ready head has no effect
        retire_en = 1; cycle();
        chk("R3", "no_retire", free_cnt, 0);

        // R9: completion makes the head ready, then it retires
        cmpl_valid = 1; cmpl_idx = IW'(m_head); cycle();
        chk("R9", "cmpl_head_ready", head_ready, 1);
        retire_en = 1; cycle();

        // R2: dispatch and retire in the same cycle
        cmpl_valid = 1; cmpl_idx = IW'(m_head); cycle();
        drive_disp(); retire_en = 1; cycle();
        chk("R2", "same_cycle", free_cnt, 1);

        // R5: target 5 entries back from the tail (6 lane uses -> 3 cycles)
        squash_valid = 1; squash_seq = m_seq[(m_tail + DEPTH - 6) % DEPTH]; cycle();
        chk("R5", "walk_low", squash_done, 0);
        squash_valid = 1; squash_seq = 0; cycle();   // ignored while walking (R4)
        wait_walk();
        chk("R5", "tail_after", tail_seq, next_seq - 1);

        // R5: target equals the tail itself, no marks, one cycle
        drive_disp(); cycle();
        squash_valid = 1; squash_seq = m_seq[(m_tail + DEPTH - 1) % DEPTH]; cycle();
        wait_walk();

        // R4: squash and dispatch in the same cycle squash the new entry
        squash_valid = 1; squash_seq = m_seq[(m_tail + DEPTH - 1) % DEPTH];
        drive_disp(); cycle(); wait_walk();

        // R6/R7: drain, then squash below the oldest entry walks to the head
        for (int i = 0; i < DEPTH; i++) begin
            if (m_cnt != 0 && !m_rdy[m_head]) begin cmpl_valid = 1; cmpl_idx = IW'(m_head); cycle(); end
            if (m_cnt != 0) begin retire_en = 1; cycle(); end
        end
        for (int i = 0; i < 5; i++) begin drive_disp(); cycle(); end
        squash_valid = 1; squash_seq = m_seq[m_head] - 1; cycle(); wait_walk();
        chk("R7", "head_sq", head_squashed, 1);
        chk("R6", "drain_ready", head_ready, 1);

        // R4: lone entry retired in the same cycle as a squash request
        while (m_cnt != 0) begin retire_en = 1; cycle(); end
        drive_disp(); cycle();
        cmpl_valid = 1; cmpl_idx = IW'(m_head); cycle();
        retire_en = 1; squash_valid = 1; squash_seq = m_seq[m_head]; cycle(); wait_walk();
        chk("R4", "lone_empty", free_cnt, DEPTH);

        // Seeded random traffic
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 3 != 0) drive_disp();
            if ($urandom % 2 == 0) retire_en = 1;
            if (m_cnt != 0 && $urandom % 2 == 0) begin
                cmpl_valid = 1; cmpl_idx = IW'((m_head + $urandom % m_cnt) % DEPTH);
            end
            if (m_cnt != 0 && $urandom % 30 == 0) begin
                squash_valid = 1;
                if ($urandom % 4 == 0) squash_seq = m_seq[m_head] - 1;
                else squash_seq = m_seq[(m_head + $urandom % m_cnt) % DEPTH];
            end
            cycle();
        end
        wait_walk();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule